// File: doc/BRIEF.md
# GCR Disk Read Byte Framer

This block sits behind the bit-recovery stage of a floppy disk read channel. Each cycle that `bit_valid` is high, one recovered bit enters a ten-bit window. A run of ten ones is a sync mark. The sync mark holds the bit counter at zero, and the counter then frames the stream that follows into ten-bit groups. The block pulses `byte_rdy` on the last bit of each group. It keeps a latched, active-low copy of that event, `byte_rdy_lat_n`, which stays low until the host touches the data port.

Every accepted bit also forms an 11-bit address into a built-in GCR table. In read mode the address is the mode bit above the ten-bit window, and the table returns the decoded low nibble together with a validity flag. In write mode the address carries the host's write byte and a write-sync bit, and the table returns the 5-bit code to be written. From the table output and `byte_rdy` the block derives `gcr_err`. When `run` is low the framer is idle: all four flags rest at 1 and the window and counter are cleared.

The bit input is a stream with a valid strobe and no ready. The disk cannot be stalled, so every strobed bit is taken in the cycle it arrives. A source must never expect back-pressure, and a bit offered while `run` is low is dropped.

Top module: `gcr_byte_framer`

## Requirements
- R1: On each accepted bit (`run` and `bit_valid` high), the 10-bit window shifts left and the new bit enters bit 0. In read mode the window is visible as `dec_addr[9:0]` one cycle later.
- R2: `sync_n` is 0 exactly when all ten window bits are 1 after the last accepted bit, and 1 otherwise.
- R3: The frame counter is 0 while sync is asserted. It does not advance on the bit where sync deasserts. On each later accepted bit it counts 0..9 and wraps to 0.
- R4: `byte_rdy` is 1 exactly when the frame counter, after the last accepted bit, equals 9.
- R5: `byte_rdy_lat_n` goes to 0 on the accepted bit where `byte_rdy` goes from 1 to 0. Otherwise `host_access` sets it to 1. If both happen in the same cycle, the fall wins.
- R6: The decode address has this form. In read mode (`rw_read`=1) it is {1, window}. In write mode it is 0x300 OR (`wr_data[7:4]` << 5) OR (`wr_sync` << 4) OR `wr_data[3:0]`.
- R7: After an accepted bit, `gcr_err` = NOT(`byte_rdy` OR `dec_out[3]`).
- R8: The table uses the nibble-to-code map 0:0A 1:0B 2:12 3:13 4:0E 5:0F 6:16 7:17 8:09 9:19 A:1A B:1B C:0D D:1D E:1E F:15. For a read address (bit 10 = 1) it returns {nibble of addr[4:0], both 5-bit halves valid, 000}, and an invalid half decodes to nibble 0. For a write address it returns {code, 000}, where code is 11111 if addr[4]=1 and otherwise the code of addr[3:0].
- R9: While `run` is low, and after reset, `sync_n`, `byte_rdy`, `byte_rdy_lat_n` and `gcr_err` are 1, and the window and counter are cleared. Reset also clears `dec_addr` and `dec_out`.
- R10: A cycle with `run` high and `bit_valid` low changes no output except through `host_access` (R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Framer enable; low means idle |
| bit_valid | input | 1 | Strobe that qualifies `bit_in` |
| bit_in | input | 1 | Recovered disk bit |
| rw_read | input | 1 | 1 = read mode, 0 = write mode |
| wr_data | input | 8 | Host write byte |
| wr_sync | input | 1 | Write sync mark request |
| host_access | input | 1 | Host access to the data port |
| sync_n | output | 1 | Sync detected, active low |
| byte_rdy | output | 1 | Frame complete pulse |
| byte_rdy_lat_n | output | 1 | Latched frame complete, active low |
| gcr_err | output | 1 | GCR error flag |
| dec_addr | output | 11 | Decode table address |
| dec_out | output | 8 | Decode table output |

## Verification
Every output is a register that is loaded on the edge that accepts a bit, so each result is due one cycle after its stimulus. A `host_access` or `run` change also takes effect at that next edge. The bench drives on the falling edge and samples 1 ns after the following rising edge. A cycle model it advances in step with that edge supplies the expected value of every output. Gaps in `bit_valid` and mid-stream `run` drops test the hold and idle rules at that same point.

// File: rtl/gcr_fr_pkg.sv
package gcr_fr_pkg;
  localparam int SR_W      = 10;
  localparam int FRAME_LEN = 10;
  localparam int ADDR_W    = SR_W + 1;
  localparam int DOUT_W    = 8;
  localparam int CNT_W     = $clog2(FRAME_LEN);

  // nibble to 5-bit GCR code
  function automatic logic [4:0] gcr_enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'h0A;  4'h1: return 5'h0B;  4'h2: return 5'h12;  4'h3: return 5'h13;
      4'h4: return 5'h0E;  4'h5: return 5'h0F;  4'h6: return 5'h16;  4'h7: return 5'h17;
      4'h8: return 5'h09;  4'h9: return 5'h19;  4'hA: return 5'h1A;  4'hB: return 5'h1B;
      4'hC: return 5'h0D;  4'hD: return 5'h1D;  4'hE: return 5'h1E;  default: return 5'h15;
    endcase
  endfunction

  // 5-bit code to {valid, nibble}, computed by inverting the encoder
  function automatic logic [4:0] gcr_dec(input logic [4:0] c);
    logic [4:0] r;
    r = '0;
    for (int k = 0; k < 16; k++)
      if (gcr_enc(4'(k)) == c) r = {1'b1, 4'(k)};
    return r;
  endfunction

  function automatic logic [DOUT_W-1:0] gcr_table(input logic [ADDR_W-1:0] a);
    logic [4:0] lo, hi, code;
    lo = gcr_dec(a[4:0]);
    hi = gcr_dec(a[9:5]);
    code = a[4] ? 5'h1F : gcr_enc(a[3:0]);
    if (a[10]) return {lo[3:0], lo[4] & hi[4], 3'b000};
    else       return {code, 3'b000};
  endfunction
endpackage

// File: rtl/gcr_fr_shift.sv
module gcr_fr_shift #(
  parameter int SR_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            idle,
  input  logic            accept,
  input  logic            bit_in,
  output logic [SR_W-1:0] sr_q,
  output logic [SR_W-1:0] sr_nx,
  output logic            sync_nx_n,
  output logic            sync_q_n
);
  assign sr_nx     = {sr_q[SR_W-2:0], bit_in};
  assign sync_nx_n = ~(&sr_nx);

  always_ff @(posedge clk) begin
    if (rst || idle) begin
      sr_q     <= '0;
      sync_q_n <= 1'b1;
    end else if (accept) begin
      sr_q     <= sr_nx;
      sync_q_n <= sync_nx_n;
    end
  end
endmodule

// File: rtl/gcr_fr_count.sv
module gcr_fr_count #(
  parameter int FRAME_LEN = 10,
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle,
  input  logic             accept,
  input  logic             host_access,
  input  logic             sync_nx_n,
  input  logic             sync_q_n,
  output logic [CNT_W-1:0] cnt_q,
  output logic             brdy_nx,
  output logic             brdy_q,
  output logic             lbrdy_n_q
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    if (!sync_nx_n)    cnt_nx = '0;
    else if (sync_q_n) cnt_nx = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    else               cnt_nx = cnt_q;
  end
  assign brdy_nx = (cnt_nx == LAST);

  always_ff @(posedge clk) begin
    if (rst || idle) begin
      cnt_q     <= '0;
      brdy_q    <= 1'b1;
      lbrdy_n_q <= 1'b1;
    end else begin
      if (accept) begin
        cnt_q  <= cnt_nx;
        brdy_q <= brdy_nx;
      end
      if (accept && brdy_q && !brdy_nx) lbrdy_n_q <= 1'b0;
      else if (host_access)             lbrdy_n_q <= 1'b1;
    end
  end
endmodule

// File: rtl/gcr_fr_decode.sv
module gcr_fr_decode
  import gcr_fr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              idle,
  input  logic              accept,
  input  logic              rw_read,
  input  logic [7:0]        wr_data,
  input  logic              wr_sync,
  input  logic [SR_W-1:0]   sr_nx,
  input  logic              brdy_nx,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DOUT_W-1:0] dout_q,
  output logic              gerr_q
);
  logic [ADDR_W-1:0] addr_nx;
  logic [DOUT_W-1:0] dout_nx;

  always_comb begin
    if (rw_read) addr_nx = {1'b1, sr_nx};
    else         addr_nx = 11'h300 | {2'b00, wr_data[7:4], 5'b0}
                                   | {6'b0, wr_sync, 4'b0}
                                   | {7'b0, wr_data[3:0]};
  end
  assign dout_nx = gcr_table(addr_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      dout_q <= '0;
      gerr_q <= 1'b1;
    end else if (idle) begin
      gerr_q <= 1'b1;
    end else if (accept) begin
      addr_q <= addr_nx;
      dout_q <= dout_nx;
      gerr_q <= ~(brdy_nx | dout_nx[3]);
    end
  end
endmodule

// File: rtl/gcr_byte_framer.sv
module gcr_byte_framer
  import gcr_fr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              rw_read,
  input  logic [7:0]        wr_data,
  input  logic              wr_sync,
  input  logic              host_access,
  output logic              sync_n,
  output logic              byte_rdy,
  output logic              byte_rdy_lat_n,
  output logic              gcr_err,
  output logic [ADDR_W-1:0] dec_addr,
  output logic [DOUT_W-1:0] dec_out
);
  logic            idle, accept;
  logic [SR_W-1:0] sr_q, sr_nx;
  logic            sync_nx_n;
  logic [CNT_W-1:0] cnt_q;
  logic            brdy_nx;

  assign idle   = ~run;
  assign accept = run & bit_valid;

  gcr_fr_shift #(.SR_W(SR_W)) u_shift (
    .clk(clk), .rst(rst), .idle(idle), .accept(accept), .bit_in(bit_in),
    .sr_q(sr_q), .sr_nx(sr_nx), .sync_nx_n(sync_nx_n), .sync_q_n(sync_n)
  );

  gcr_fr_count #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .idle(idle), .accept(accept), .host_access(host_access),
    .sync_nx_n(sync_nx_n), .sync_q_n(sync_n), .cnt_q(cnt_q),
    .brdy_nx(brdy_nx), .brdy_q(byte_rdy), .lbrdy_n_q(byte_rdy_lat_n)
  );

  gcr_fr_decode u_decode (
    .clk(clk), .rst(rst), .idle(idle), .accept(accept), .rw_read(rw_read),
    .wr_data(wr_data), .wr_sync(wr_sync), .sr_nx(sr_nx), .brdy_nx(brdy_nx),
    .addr_q(dec_addr), .dout_q(dec_out), .gerr_q(gcr_err)
  );
endmodule

// File: rtl/gcr_fr_checker.sv
module gcr_fr_checker
  import gcr_fr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              bit_valid,
  input logic              host_access,
  input logic              sync_n,
  input logic              byte_rdy,
  input logic              byte_rdy_lat_n,
  input logic              gcr_err,
  input logic [DOUT_W-1:0] dec_out,
  input logic [SR_W-1:0]   sr,
  input logic [CNT_W-1:0]  cnt
);
  p_sync_ones_r2: assert property (@(posedge clk) disable iff (rst)
    (run && bit_valid) |=> (sync_n == !(&sr)));
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(FRAME_LEN));
  p_sync_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !sync_n |-> (cnt == '0));
  p_brdy_at_last_r4: assert property (@(posedge clk) disable iff (rst)
    (run && bit_valid) |=> (byte_rdy == (cnt == CNT_W'(FRAME_LEN - 1))));
  p_lat_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(byte_rdy) |-> !byte_rdy_lat_n);
  p_lat_host_r5: assert property (@(posedge clk) disable iff (rst)
    (host_access && !(run && bit_valid)) |=> byte_rdy_lat_n);
  p_gerr_r7: assert property (@(posedge clk) disable iff (rst)
    (run && bit_valid) |=> (gcr_err == !(byte_rdy || dec_out[3])));
  p_idle_flags_r9: assert property (@(posedge clk) disable iff (rst)
    !run |=> (sync_n && byte_rdy && byte_rdy_lat_n && gcr_err));
  p_gap_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (run && !bit_valid) |=> ($stable(sr) && $stable(cnt) && $stable(byte_rdy) && $stable(dec_out)));
endmodule

bind gcr_byte_framer gcr_fr_checker u_chk (
  .clk(clk), .rst(rst), .run(run), .bit_valid(bit_valid), .host_access(host_access),
  .sync_n(sync_n), .byte_rdy(byte_rdy), .byte_rdy_lat_n(byte_rdy_lat_n),
  .gcr_err(gcr_err), .dec_out(dec_out), .sr(sr_q), .cnt(cnt_q)
);

// File: tb/sim_gcr_byte_framer.sv
`timescale 1ns/1ps
module sim_gcr_byte_framer;
  logic clk = 1'b0;
  logic rst, run, bit_valid, bit_in, rw_read, wr_sync, host_access;
  logic [7:0] wr_data;
  logic sync_n, byte_rdy, byte_rdy_lat_n, gcr_err;
  logic [10:0] dec_addr;
  logic [7:0] dec_out;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  gcr_byte_framer u0 (
    .clk(clk), .rst(rst), .run(run), .bit_valid(bit_valid), .bit_in(bit_in),
    .rw_read(rw_read), .wr_data(wr_data), .wr_sync(wr_sync), .host_access(host_access),
    .sync_n(sync_n), .byte_rdy(byte_rdy), .byte_rdy_lat_n(byte_rdy_lat_n),
    .gcr_err(gcr_err), .dec_addr(dec_addr), .dec_out(dec_out)
  );

  // R8 code map
  localparam logic [4:0] CODES [16] = '{5'h0A, 5'h0B, 5'h12, 5'h13, 5'h0E, 5'h0F, 5'h16, 5'h17,
                                        5'h09, 5'h19, 5'h1A, 5'h1B, 5'h0D, 5'h1D, 5'h1E, 5'h15};

  function automatic logic [7:0] ref_table(input logic [10:0] a);
    logic [3:0] nib; logic vlo, vhi;
    nib = 4'h0; vlo = 1'b0; vhi = 1'b0;
    for (int k = 0; k < 16; k++) begin
      if (CODES[k] == a[4:0]) begin nib = 4'(k); vlo = 1'b1; end
      if (CODES[k] == a[9:5]) vhi = 1'b1;
    end
    if (a[10]) return {nib, vlo & vhi, 3'b000};
    return {(a[4] ? 5'h1F : CODES[a[3:0]]), 3'b000};
  endfunction

  // reference state
  logic [9:0] m_sr; int m_cnt; logic m_sync_n, m_brdy, m_lb_n, m_gerr;
  logic [10:0] m_addr; logic [7:0] m_dout;

  task automatic model_reset();
    m_sr = '0; m_cnt = 0; m_sync_n = 1; m_brdy = 1; m_lb_n = 1; m_gerr = 1;
    m_addr = '0; m_dout = '0;
  endtask

  task automatic model_step();
    logic [9:0] s; logic sn, b; int c;
    if (!run) begin
      m_sr = '0; m_cnt = 0; m_sync_n = 1; m_brdy = 1; m_lb_n = 1; m_gerr = 1;
    end else if (bit_valid) begin
      s  = {m_sr[8:0], bit_in};
      sn = (s != 10'h3FF);
      if (!sn) c = 0;
      else if (m_sync_n) c = (m_cnt == 9) ? 0 : m_cnt + 1;
      else c = m_cnt;
      b = (c == 9);
      m_addr = rw_read ? {1'b1, s}
                       : (11'h300 | (11'(wr_data[7:4]) << 5) | (11'(wr_sync) << 4) | 11'(wr_data[3:0]));
      m_dout = ref_table(m_addr);
      m_gerr = !(b || m_dout[3]);
      if (m_brdy && !b) m_lb_n = 0; else if (host_access) m_lb_n = 1;
      m_sr = s; m_cnt = c; m_sync_n = sn; m_brdy = b;
    end else if (host_access) m_lb_n = 1;
  endtask

  task automatic chk1(input string req, input string nm, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk1("R2", "sync_n", 11'(sync_n), 11'(m_sync_n));
    chk1("R4", "byte_rdy", 11'(byte_rdy), 11'(m_brdy));
    chk1("R5", "byte_rdy_lat_n", 11'(byte_rdy_lat_n), 11'(m_lb_n));
    chk1("R7", "gcr_err", 11'(gcr_err), 11'(m_gerr));
    chk1("R6", "dec_addr", dec_addr, m_addr);   // R1 window via dec_addr[9:0]
    chk1("R8", "dec_out", 11'(dec_out), 11'(m_dout));
  endtask

  // called at negedge with inputs set
  task automatic step();
    model_step();
    @(posedge clk); #1;
    compare_all();
    @(negedge clk);
  endtask

  // row: run, rw_read, host, wsync, gap, wd[7:0], nbits[4:0], pattern[15:0]
  typedef struct packed {
    logic r; logic rw; logic h; logic ws; logic gap;
    logic [7:0] wd; logic [4:0] n; logic [15:0] pat;
  } row_t;
  localparam int NROWS = 12;
  localparam row_t ROWS [NROWS] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 5'd12, 16'h0FFF},  // R2 sync mark
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 5'd10, 16'h014B},  // R3/R8 codes 0A 0B
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 5'd10, 16'h0253},  // R10 gaps, codes 12 13
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 5'd10, 16'h0000},  // R7 invalid codes
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 5'd3,  16'h0005},  // R5 host clears
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 5'd12, 16'h0FFC},  // R3 resync
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 5'd16, 16'hB6D5},  // R5 fall with host
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A, 5'd4,  16'h0009},  // R6 write mode
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC3, 5'd3,  16'h0000},  // R6 write sync
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 5'd16, 16'hA5A5},  // R1 window
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 5'd2,  16'h0003},  // R9 idle
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 5'd14, 16'h3FF6}   // R3 restart after idle
  };

  initial begin
    rst = 1; run = 0; bit_valid = 0; bit_in = 0; rw_read = 1; wr_data = 0; wr_sync = 0; host_access = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R9 reset state
    compare_all();
    for (int r = 0; r < NROWS; r++) begin
      for (int b = int'(ROWS[r].n) - 1; b >= 0; b--) begin
        run = ROWS[r].r; rw_read = ROWS[r].rw; host_access = ROWS[r].h;
        wr_sync = ROWS[r].ws; wr_data = ROWS[r].wd;
        bit_in = ROWS[r].pat[b]; bit_valid = 1;
        step();
        if (ROWS[r].gap) begin
          bit_valid = 0; bit_in = ~bit_in;  // R10 ignored bit
          step();
        end
      end
    end
    // directed R5: latch low, then host access alone sets it
    run = 1; rw_read = 1; host_access = 0; bit_valid = 1;
    for (int k = 0; k < 10; k++) begin bit_in = 1; step(); end
    for (int k = 0; k < 11; k++) begin bit_in = k[0]; step(); end
    chk1("R5", "latched low after frame", 11'(byte_rdy_lat_n), 11'd0);
    bit_valid = 0; host_access = 1; step();
    chk1("R5", "host sets latch", 11'(byte_rdy_lat_n), 11'd1);
    host_access = 0;
    // directed R9: mid-stream reset clears everything
    bit_valid = 1; bit_in = 1; step();
    rst = 1; model_reset(); @(posedge clk); #1;
    compare_all();
    @(negedge clk); rst = 0; run = 0; bit_valid = 0;
    step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule